// File: doc/BRIEF.md
# Dual-Space Data Memory Router

This block sits between a 16-bit core's address generators and its data memory. The byte-addressed space is laid out bottom-up as a special-function-register window, then an X RAM block, then a Y RAM block, then unimplemented space. The X/Y split point and the top of implemented RAM are parameters. The core presents one request per cycle in one of four classes:
- a general read;
- a general write;
- a dual-operand signal-processing read;
- an accumulator write-back store.

General reads and all writes treat X and Y as one flat space. A dual-operand read fetches one word from X and one from Y in the same cycle. The working-register number that supplied each operand pointer decides which slot that pointer may feed.

Every request gets a registered response one cycle later. The response carries the operand words and a single-cycle address-error pulse. A pointer that lands in the other operand's RAM reads as zero without faulting. Misaligned, unimplemented or wrongly-sourced accesses fault, and a faulting write leaves memory untouched.

A small response state machine has three states:
- ST_IDLE: no response this cycle.
- ST_DATA: a clean response.
- ST_TRAP: a faulting response.

The machine moves on each clock. It goes to ST_TRAP when a request faults, to ST_DATA when a request is clean, and to ST_IDLE when there is no request. These transitions apply from every state.

Top module: `dmr_route_unit`

## Requirements
- R1: Byte addresses below SFR_TOP (default 0x0800) decode as SFR space. Addresses in [SFR_TOP, X_END) decode as X RAM and addresses in [X_END, RAM_END) decode as Y RAM. Defaults are X_END=0x0900 and RAM_END=0x0A00. Anything at or above RAM_END is unimplemented.
- R2: A request with `req_valid` high produces `rsp_valid` high on the next cycle. A cycle without a request produces `rsp_valid` low on the next cycle.
- R3: A general write (`req_kind`=2'b01) stores `req_wdata` at `req_addr` in the combined space. A general read (`req_kind`=2'b00) returns that word on `rsp_xdata`, whatever `req_ptr` is. Writes and general reads return 0 on `rsp_ydata`, and writes also return 0 on `rsp_xdata`.
- R4: A dual-operand read (`req_kind`=2'b10) returns the X RAM word at `xa_addr` on `rsp_xdata` and the Y RAM word at `ya_addr` on `rsp_ydata`, in the same response.
- R5: In a dual-operand read, an X-slot pointer that lands in Y RAM or SFR space gives 0 on `rsp_xdata` without a trap. A Y-slot pointer that lands in X RAM or SFR space gives 0 on `rsp_ydata` without a trap.
- R6: In a dual-operand read, `xa_ptr` must be 8 or 9 and `ya_ptr` must be 10 or 11. Any other value raises `rsp_trap`.
- R7: An access to unimplemented space raises `rsp_trap`. This holds for any request class and either operand slot.
- R8: An odd byte address (bit 0 set) raises `rsp_trap`. This holds for any request class and either operand slot.
- R9: An accumulator write-back (`req_kind`=2'b11) writes like a general write only when `req_ptr` is 13. Any other pointer raises `rsp_trap`.
- R10: `rsp_trap` is a one-cycle pulse aligned with `rsp_valid`. A trapped response carries 0 on both data outputs, and a trapped write changes no memory word.
- R11: The SFR stub holds SFR_WORDS (default 8) words at byte addresses 0 to 2*SFR_WORDS-2. Other SFR-space addresses read 0 and ignore writes.
- R12: In reset, and on the first cycle after it, `rsp_valid`, `rsp_trap` and both data outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 general read, 01 general write, 10 dual-operand read, 11 accumulator write-back |
| req_addr | input | 16 | Byte address for general and write-back requests |
| req_ptr | input | 4 | Working-register number behind req_addr |
| req_wdata | input | 16 | Write data |
| xa_addr | input | 16 | X-slot byte address for dual-operand reads |
| xa_ptr | input | 4 | Register number behind xa_addr |
| ya_addr | input | 16 | Y-slot byte address for dual-operand reads |
| ya_ptr | input | 4 | Register number behind ya_addr |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 1 | Address-error pulse |
| rsp_xdata | output | 16 | General read data or X operand |
| rsp_ydata | output | 16 | Y operand |

## Verification
A wrong response state shows up on the very next cycle as a missing or extra `rsp_valid` or a misplaced `rsp_trap`. A wrong registered source selection shows up in that same response as a word from the wrong RAM, or as a nonzero word where zero-fill is due. A corrupted write path stays hidden until a later read of that address. For this reason every write, trapped or clean, is followed by a read-back of the word it targeted, and of the word a misaligned write would have aliased.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    typedef enum logic [1:0] {
        K_GEN_RD = 2'b00,
        K_GEN_WR = 2'b01,
        K_DUAL_RD = 2'b10,
        K_ACC_WB = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        RG_SFR = 2'd0,
        RG_X = 2'd1,
        RG_Y = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_SFR = 2'd1,
        SRC_X = 2'd2,
        SRC_Y = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_TRAP = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/dmr_decode.sv
module dmr_decode
    import dmr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SFR_TOP = 'h0800,
    parameter int X_END = 'h0900,
    parameter int RAM_END = 'h0A00
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              odd
);
    localparam logic [ADDR_W-1:0] SFR_TOP_A = ADDR_W'(SFR_TOP);
    localparam logic [ADDR_W-1:0] X_END_A = ADDR_W'(X_END);
    localparam logic [ADDR_W-1:0] RAM_END_A = ADDR_W'(RAM_END);

    always_comb begin
        if (addr < SFR_TOP_A) begin
            region = RG_SFR;
        end else if (addr < X_END_A) begin
            region = RG_X;
        end else if (addr < RAM_END_A) begin
            region = RG_Y;
        end else begin
            region = RG_NONE;
        end
        odd = addr[0];
    end
endmodule

// File: rtl/dmr_bank.sv
module dmr_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH = 128,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic [IW-1:0]     idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
        rdata <= mem[idx];
    end
endmodule

// File: rtl/dmr_sfr_stub.sv
module dmr_sfr_stub #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WORDS = 8,
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WORDS * 2);

    logic [DATA_W-1:0] regs [WORDS];
    logic [IW-1:0]     idx;
    logic              hit;

    always_comb begin
        idx = IW'(addr >> 1);
        hit = addr < LIMIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                regs[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (we && hit) begin
                regs[idx] <= wdata;
            end
            rdata <= hit ? regs[idx] : '0;
        end
    end
endmodule

// File: rtl/dmr_route_unit.sv
module dmr_route_unit
    import dmr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SFR_TOP = 'h0800,
    parameter int X_END = 'h0900,
    parameter int RAM_END = 'h0A00,
    parameter int SFR_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_ptr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] xa_addr,
    input  logic [3:0]        xa_ptr,
    input  logic [ADDR_W-1:0] ya_addr,
    input  logic [3:0]        ya_ptr,
    output logic              rsp_valid,
    output logic              rsp_trap,
    output logic [DATA_W-1:0] rsp_xdata,
    output logic [DATA_W-1:0] rsp_ydata
);
    localparam int X_WORDS = (X_END - SFR_TOP) / 2;
    localparam int Y_WORDS = (RAM_END - X_END) / 2;
    localparam int X_IW = (X_WORDS > 1) ? $clog2(X_WORDS) : 1;
    localparam int Y_IW = (Y_WORDS > 1) ? $clog2(Y_WORDS) : 1;
    localparam logic [ADDR_W-1:0] X_BASE = ADDR_W'(SFR_TOP);
    localparam logic [ADDR_W-1:0] Y_BASE = ADDR_W'(X_END);
    localparam logic [3:0] PTR_ACC = 4'd13;

    req_kind_e  kind;
    region_e    rg_main, rg_xa, rg_ya;
    logic       odd_main, odd_xa, odd_ya;
    logic       is_dual, is_write, fault, wr_ok;
    logic       x_ptr_ok, y_ptr_ok;
    src_e       src_x_d, src_x_q, src_y_d, src_y_q;
    rsp_state_e state_q, state_d;
    logic [ADDR_W-1:0] x_sel, y_sel;
    logic [X_IW-1:0]   x_idx;
    logic [Y_IW-1:0]   y_idx;
    logic              x_we, y_we, sfr_we;
    logic [DATA_W-1:0] x_rd, y_rd, sfr_rd;

    assign kind = req_kind_e'(req_kind);

    dmr_decode #(.ADDR_W(ADDR_W), .SFR_TOP(SFR_TOP), .X_END(X_END), .RAM_END(RAM_END))
        dec_main_i (.addr(req_addr), .region(rg_main), .odd(odd_main));
    dmr_decode #(.ADDR_W(ADDR_W), .SFR_TOP(SFR_TOP), .X_END(X_END), .RAM_END(RAM_END))
        dec_xa_i (.addr(xa_addr), .region(rg_xa), .odd(odd_xa));
    dmr_decode #(.ADDR_W(ADDR_W), .SFR_TOP(SFR_TOP), .X_END(X_END), .RAM_END(RAM_END))
        dec_ya_i (.addr(ya_addr), .region(rg_ya), .odd(odd_ya));

    // Request classification and fault detection
    always_comb begin
        is_dual  = (kind == K_DUAL_RD);
        is_write = (kind == K_GEN_WR) || (kind == K_ACC_WB);
        x_ptr_ok = (xa_ptr == 4'd8) || (xa_ptr == 4'd9);
        y_ptr_ok = (ya_ptr == 4'd10) || (ya_ptr == 4'd11);
        if (is_dual) begin
            fault = !x_ptr_ok || !y_ptr_ok || odd_xa || odd_ya
                    || (rg_xa == RG_NONE) || (rg_ya == RG_NONE);
        end else begin
            fault = odd_main || (rg_main == RG_NONE)
                    || ((kind == K_ACC_WB) && (req_ptr != PTR_ACC));
        end
        wr_ok = req_valid && is_write && !fault;
    end

    // Source selection for the registered response
    always_comb begin
        src_y_d = (is_dual && rg_ya == RG_Y) ? SRC_Y : SRC_ZERO;
        if (is_dual) begin
            src_x_d = (rg_xa == RG_X) ? SRC_X : SRC_ZERO;
        end else if (is_write) begin
            src_x_d = SRC_ZERO;
        end else begin
            unique case (rg_main)
                RG_SFR:  src_x_d = SRC_SFR;
                RG_X:    src_x_d = SRC_X;
                RG_Y:    src_x_d = SRC_Y;
                default: src_x_d = SRC_ZERO;
            endcase
        end
    end

    // Bank port addressing and write enables
    always_comb begin
        x_sel  = is_dual ? xa_addr : req_addr;
        y_sel  = is_dual ? ya_addr : req_addr;
        x_idx  = X_IW'((x_sel - X_BASE) >> 1);
        y_idx  = Y_IW'((y_sel - Y_BASE) >> 1);
        x_we   = wr_ok && (rg_main == RG_X);
        y_we   = wr_ok && (rg_main == RG_Y);
        sfr_we = wr_ok && (rg_main == RG_SFR);
    end

    dmr_bank #(.DATA_W(DATA_W), .DEPTH(X_WORDS)) x_bank_i (
        .clk(clk), .idx(x_idx), .we(x_we), .wdata(req_wdata), .rdata(x_rd));
    dmr_bank #(.DATA_W(DATA_W), .DEPTH(Y_WORDS)) y_bank_i (
        .clk(clk), .idx(y_idx), .we(y_we), .wdata(req_wdata), .rdata(y_rd));
    dmr_sfr_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(SFR_WORDS)) sfr_i (
        .clk(clk), .rst_n(rst_n), .addr(req_addr), .we(sfr_we),
        .wdata(req_wdata), .rdata(sfr_rd));

    // Next state
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (fault) begin
            state_d = ST_TRAP;
        end else begin
            state_d = ST_DATA;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_x_q <= SRC_ZERO;
            src_y_q <= SRC_ZERO;
        end else begin
            state_q <= state_d;
            src_x_q <= src_x_d;
            src_y_q <= src_y_d;
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_trap  = 1'b0;
        rsp_xdata = '0;
        rsp_ydata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DATA: begin
                rsp_valid = 1'b1;
                unique case (src_x_q)
                    SRC_SFR:  rsp_xdata = sfr_rd;
                    SRC_X:    rsp_xdata = x_rd;
                    SRC_Y:    rsp_xdata = y_rd;
                    default:  rsp_xdata = '0;
                endcase
                rsp_ydata = (src_y_q == SRC_Y) ? y_rd : '0;
            end
            ST_TRAP: begin
                rsp_valid = 1'b1;
                rsp_trap  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dmr_route_chk.sv
module dmr_route_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int RAM_END = 'h0A00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_ptr,
    input logic [3:0]        xa_ptr,
    input logic [3:0]        ya_ptr,
    input logic              rsp_valid,
    input logic              rsp_trap,
    input logic [DATA_W-1:0] rsp_xdata,
    input logic [DATA_W-1:0] rsp_ydata
);
    localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(RAM_END);

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_quiet_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_xslot_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10 && xa_ptr != 4'd8 && xa_ptr != 4'd9) |=> rsp_trap);
    p_yslot_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10 && ya_ptr != 4'd10 && ya_ptr != 4'd11) |=> rsp_trap);
    p_unimpl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'b10 && req_addr >= TOP_A) |=> rsp_trap);
    p_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 2'b10 && req_addr[0]) |=> rsp_trap);
    p_accwb_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11 && req_ptr != 4'd13) |=> rsp_trap);
    p_trap_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_valid && rsp_xdata == '0 && rsp_ydata == '0));
    p_trap_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap && !$past(req_valid)) |-> 1'b0);
    p_write_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[0]) |=> (rsp_xdata == '0 && rsp_ydata == '0));
endmodule

bind dmr_route_unit dmr_route_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_END(RAM_END)) chk_i (.*);

// File: tb/dmr_route_unit_tb_top.sv
module dmr_route_unit_tb_top;
    localparam int SFR_TOP = 'h0800;
    localparam int X_END = 'h0900;
    localparam int RAM_END = 'h0A00;
    localparam int SFR_WORDS = 8;

    typedef struct {
        logic        trap;
        logic [15:0] xd;
        logic [15:0] yd;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [15:0] req_addr = '0, req_wdata = '0, xa_addr = '0, ya_addr = '0;
    logic [3:0] req_ptr = '0, xa_ptr = '0, ya_ptr = '0;
    logic rsp_valid, rsp_trap;
    logic [15:0] rsp_xdata, rsp_ydata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t q[$];
    logic [15:0] mdl [int];

    always #2 clk = ~clk;

    dmr_route_unit #(.SFR_TOP(SFR_TOP), .X_END(X_END), .RAM_END(RAM_END),
                     .SFR_WORDS(SFR_WORDS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_ptr(req_ptr), .req_wdata(req_wdata),
        .xa_addr(xa_addr), .xa_ptr(xa_ptr), .ya_addr(ya_addr), .ya_ptr(ya_ptr),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap),
        .rsp_xdata(rsp_xdata), .rsp_ydata(rsp_ydata));

    // R1 region code: 0 SFR, 1 X, 2 Y, 3 unimplemented
    function automatic int region(input logic [15:0] a);
        if (a < SFR_TOP) return 0;
        if (a < X_END) return 1;
        if (a < RAM_END) return 2;
        return 3;
    endfunction

    function automatic logic [15:0] peek(input logic [15:0] a);
        if (region(a) == 0 && a >= 2 * SFR_WORDS) return 16'h0000;
        if (mdl.exists(int'(a))) return mdl[int'(a)];
        return 16'h0000;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [15:0] a, input logic [3:0] p,
                        input logic [15:0] wd, input logic [15:0] xa, input logic [3:0] xp,
                        input logic [15:0] ya, input logic [3:0] yp, input string tag);
        exp_t e;
        bit bad;
        @(negedge clk);
        e.xd = '0;
        e.yd = '0;
        if (k == 2'b10) begin
            bad = !(xp == 8 || xp == 9) || !(yp == 10 || yp == 11) || xa[0] || ya[0]
                  || region(xa) == 3 || region(ya) == 3;
            if (region(xa) == 1) e.xd = peek(xa);
            if (region(ya) == 2) e.yd = peek(ya);
        end else begin
            bad = a[0] || region(a) == 3 || (k == 2'b11 && p != 4'd13);
            if (k == 2'b00) e.xd = peek(a);
        end
        if (bad) begin
            e.xd = '0;
            e.yd = '0;
        end
        if (k[0] && !bad && !(region(a) == 0 && a >= 2 * SFR_WORDS)) mdl[int'(a)] = wd;
        e.trap = bad;
        e.tag = tag;
        q.push_back(e);
        req_valid = 1'b1;
        req_kind = k;
        req_addr = a;
        req_ptr = p;
        req_wdata = wd;
        xa_addr = xa;
        xa_ptr = xp;
        ya_addr = ya;
        ya_ptr = yp;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input string tag);
        send(2'b01, a, 4'd3, d, '0, 4'd8, '0, 4'd10, tag);
    endtask
    task automatic rd(input logic [15:0] a, input logic [3:0] p, input string tag);
        send(2'b00, a, p, '0, '0, 4'd8, '0, 4'd10, tag);
    endtask
    task automatic dual(input logic [15:0] xa, input logic [3:0] xp,
                        input logic [15:0] ya, input logic [3:0] yp, input string tag);
        send(2'b10, 16'h0800, 4'd0, '0, xa, xp, ya, yp, tag);
    endtask
    task automatic accwb(input logic [15:0] a, input logic [3:0] p, input logic [15:0] d,
                         input string tag);
        send(2'b11, a, p, d, '0, 4'd8, '0, 4'd10, tag);
    endtask
    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pop and compare each response
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && rsp_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected response", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rsp_trap == e.trap, e.tag, "trap", 32'(rsp_trap), 32'(e.trap));
                    check(rsp_xdata == e.xd, e.tag, "xdata", 32'(rsp_xdata), 32'(e.xd));
                    check(rsp_ydata == e.yd, e.tag, "ydata", 32'(rsp_ydata), 32'(e.yd));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(rsp_valid == 0 && rsp_trap == 0 && rsp_xdata == 0 && rsp_ydata == 0,
              "R12", "reset outputs", {rsp_valid, rsp_trap, 14'd0, rsp_xdata}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(rsp_valid == 0 && rsp_trap == 0, "R12", "after reset", 32'(rsp_valid), 32'd0);

        // R3 R1 general writes across regions, back to back (R2)
        wr(16'h0800, 16'hA001, "R3");
        wr(16'h08FE, 16'hA002, "R1");
        wr(16'h0900, 16'hB001, "R1");
        wr(16'h09FE, 16'hB002, "R1");
        wr(16'h0804, 16'hA003, "R3");
        wr(16'h0904, 16'hB003, "R3");
        wr(16'h0004, 16'h5A5A, "R11");
        wr(16'h0010, 16'h1234, "R11");
        rd(16'h0800, 4'd0, "R3");
        rd(16'h08FE, 4'd5, "R1");
        rd(16'h0900, 4'd10, "R1");
        rd(16'h09FE, 4'd15, "R1");
        rd(16'h0004, 4'd7, "R11");
        rd(16'h0010, 4'd2, "R11");
        // R4 dual-operand reads
        dual(16'h0800, 4'd8, 16'h0900, 4'd10, "R4");
        dual(16'h0804, 4'd9, 16'h0904, 4'd11, "R4");
        dual(16'h08FE, 4'd8, 16'h09FE, 4'd11, "R4");
        // R5 zero fill without trap
        dual(16'h0900, 4'd8, 16'h0900, 4'd10, "R5");
        dual(16'h0800, 4'd9, 16'h0800, 4'd11, "R5");
        dual(16'h0004, 4'd8, 16'h0004, 4'd10, "R5");
        // R6 pointer checks
        dual(16'h0800, 4'd10, 16'h0900, 4'd10, "R6");
        dual(16'h0800, 4'd8, 16'h0900, 4'd8, "R6");
        dual(16'h0800, 4'd13, 16'h0900, 4'd12, "R6");
        // R7 unimplemented space
        rd(16'h0A00, 4'd1, "R7");
        dual(16'h0800, 4'd8, 16'h0A02, 4'd10, "R7");
        wr(16'hFFFE, 16'hDEAD, "R7");
        // R8 misaligned
        rd(16'h0801, 4'd1, "R8");
        dual(16'h0805, 4'd8, 16'h0900, 4'd10, "R8");
        // R9 accumulator write-back
        accwb(16'h0802, 4'd13, 16'hC0DE, "R9");
        accwb(16'h0902, 4'd13, 16'hC0DF, "R9");
        rd(16'h0802, 4'd4, "R9");
        rd(16'h0902, 4'd4, "R9");
        // R10 trapped writes leave memory alone
        accwb(16'h0800, 4'd12, 16'hBAD0, "R10");
        wr(16'h0801, 16'hBAD1, "R10");
        wr(16'h0905, 16'hBAD2, "R10");
        rd(16'h0800, 4'd6, "R10");
        rd(16'h0904, 4'd6, "R10");
        // SFR stub overwrite
        wr(16'h000E, 16'h0F0F, "R11");
        rd(16'h000E, 4'd0, "R11");
        idle();
        repeat (2) @(posedge clk);
        #1;
        check(rsp_valid == 0, "R2", "idle response", 32'(rsp_valid), 32'd0);
        repeat (2) @(posedge clk);
        check(q.size() == 0, "R2", "outstanding", 32'(q.size()), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule